// File: doc/BRIEF.md
# SPI flash byte-access sequencer

This block moves single bytes between a host and a serial NOR flash. The host programs it through a small byte-wide register window. It loads a start address into four address byte registers and picks a read opcode. It then selects plain, fast, dual-output or quad-output reads and 3-byte or 4-byte addressing. After that it issues one command per byte and polls the command register until the command bits read back as zero. The block drives chip select, the serial clock and the four IO lines itself. The clock runs in mode 0, so the flash samples on the rising edge and changes its output on the falling edge.

A read command sends the opcode, the address, eight dummy clocks where the read mode needs them, and then collects one byte on one, two or four lines. A write command runs three steps, each in its own chip-select frame: it enables writing, programs one byte, and reads the flash status until the flash is no longer busy. After every completed command the internal address advances by one, so the host can stream bytes without reloading it. The engine accepts nothing until the host has written the unlock key.

Register offsets (byte wide): command 0x00, read data 0x0C, address bytes 0x10 (bits 7:0), 0x14 (15:8), 0x18 (23:16) and 0xC8 (31:24), write data 0x1C, single/dual read opcode 0x2C, quad read opcode 0x30, read config 0x60, lock 0xC4, mode 0xCC.

Top module: `spi_byte_seq`

## Requirements
- R1: Until the value 0x30 is held in the lock register (0xC4), writes of a command code to 0x00 are ignored: chip select stays high, 0x00 reads 0 and the address registers keep their value.
- R2: While a command is in progress, 0x00 reads back the code written. Once the command is complete it reads 0x00.
- R3: Command 0x81 performs one read: opcode from 0x2C on IO0, then the address MSB first on IO0, then the data byte, which is stored in 0x0C. With the mode register at 0 and bit 0 of 0x60 clear, there are no dummy clocks and the 8 data bits are sampled from IO1, MSB first.
- R4: With bit 0 of 0x60 set, a single-line read inserts 8 dummy clocks between the address and the data.
- R5: Mode bit 0 (0xCC) selects dual-output read: 8 dummy clocks, then 4 clocks each sampling {IO1, IO0}, most significant pair first.
- R6: Mode bit 2 selects quad-output read and takes priority over bit 0. The opcode comes from 0x30, followed by 8 dummy clocks and then 2 clocks each sampling IO3..IO0, high nibble first.
- R7: Mode bit 4 set sends a 32-bit address (0xC8, 0x18, 0x14, 0x10, MSB first). When it is clear, only the low 24 bits are sent.
- R8: Command 0x90 sends 0x06 alone in one frame. It then sends 0x02, the address and the byte from 0x1C in a second frame. It then repeats a 0x05 status frame (8 bits in on IO1) until status bit 0 reads 0. Only after that does the command complete.
- R9: After each completed command the 32-bit address advances by one, with carry across bytes, and the address registers read back the advanced value.
- R10: While a command is in progress, every register write is ignored, including a second command. A command code other than 0x81 or 0x90 is ignored.
- R11: After reset, chip select is high, the clock is low, no IO line is driven and 0x00 and 0x0C read 0. Whenever chip select is high, the clock is low and no IO line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock, idle low |
| spi_io_out | output | 4 | Values driven on IO3..IO0 |
| spi_io_oe | output | 4 | Output enables for IO3..IO0 |
| spi_io_in | input | 4 | Values sampled from IO3..IO0 |

## Verification
The assertions assume that the host writes no register while a command is in progress, other than the writes the block discards. They also assume that the flash drives the IO lines only from falling clock edges. The stimulus keeps to this: it polls the command register to completion before it reprograms anything. The single deliberate write made mid-command is there to show that it is dropped. A behavioural flash in the bench decodes every frame and answers reads from its own byte store. Its status bit stays busy for a fixed number of polls after a program operation, which exercises the status loop.

// File: rtl/fseq_pkg.sv
// Shared constants and types for the SPI flash byte-access sequencer.
// Assumes a byte-wide register window with byte offsets.
package fseq_pkg;

    localparam int ADDR_BYTES = 4;
    localparam int ADDR_W     = ADDR_BYTES * 8;

    // Register offsets seen by the host
    localparam logic [7:0] OFS_CMD     = 8'h00;
    localparam logic [7:0] OFS_RDATA   = 8'h0C;
    localparam logic [7:0] OFS_ADDR0   = 8'h10;
    localparam logic [7:0] OFS_ADDR1   = 8'h14;
    localparam logic [7:0] OFS_ADDR2   = 8'h18;
    localparam logic [7:0] OFS_WDATA   = 8'h1C;
    localparam logic [7:0] OFS_OP_STD  = 8'h2C;
    localparam logic [7:0] OFS_OP_QUAD = 8'h30;
    localparam logic [7:0] OFS_CFG     = 8'h60;
    localparam logic [7:0] OFS_LOCK    = 8'hC4;
    localparam logic [7:0] OFS_ADDR3   = 8'hC8;
    localparam logic [7:0] OFS_MODE    = 8'hCC;

    // Host command codes and unlock key
    localparam logic [7:0] CMD_RD     = 8'h81;
    localparam logic [7:0] CMD_WR     = 8'h90;
    localparam logic [7:0] UNLOCK_KEY = 8'h30;

    // Flash opcodes the write sequence issues itself
    localparam logic [7:0] FL_WREN = 8'h06;
    localparam logic [7:0] FL_PROG = 8'h02;
    localparam logic [7:0] FL_STAT = 8'h05;

    typedef enum logic [1:0] {LANE_1, LANE_2, LANE_4} lane_e;
    typedef enum logic [1:0] {SEG_TX, SEG_RX, SEG_DUMMY} seg_e;

    typedef struct packed {
        logic quad;
        logic dual;
        logic four_byte;
        logic fast;
    } rd_cfg_t;

    // Offset of address byte i (byte 3 sits apart from the others)
    function automatic logic [7:0] addr_ofs(input int i);
        case (i)
            0:       return OFS_ADDR0;
            1:       return OFS_ADDR1;
            2:       return OFS_ADDR2;
            default: return OFS_ADDR3;
        endcase
    endfunction

endpackage

// File: rtl/fseq_regs.sv
// Host register window: address counter, opcode slots, mode, lock and
// command register. Assumes writes are single-cycle strobes; every write
// that arrives while a command runs is dropped.
module fseq_regs
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cmd_done,
    input  logic [7:0]        rx_byte,
    output logic              busy,
    output logic              cmd_start,
    output logic              start_is_wr,
    output logic              unlocked,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        wr_byte,
    output logic [7:0]        op_std,
    output logic [7:0]        op_quad,
    output rd_cfg_t           rd_cfg
);

    logic [7:0] cmd_q;
    logic [7:0] rdata_q;
    logic [7:0] lock_q;
    logic       fast_q;
    logic       dual_q;
    logic       quad_q;
    logic       wide_q;
    logic       host_wr;
    logic       code_ok;

    // Qualify host writes and decode a command launch
    always_comb begin
        host_wr     = reg_wr && !busy;
        code_ok     = (reg_wdata == CMD_RD) || (reg_wdata == CMD_WR);
        unlocked    = (lock_q == UNLOCK_KEY);
        cmd_start   = host_wr && (reg_addr == OFS_CMD) && unlocked && code_ok;
        start_is_wr = (reg_wdata == CMD_WR);
        rd_cfg      = '{quad: quad_q, dual: dual_q, four_byte: wide_q, fast: fast_q};
    end

    // Register state, command tracking and address advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cmd_q    <= '0;
            rdata_q  <= '0;
            lock_q   <= '0;
            fast_q   <= 1'b0;
            dual_q   <= 1'b0;
            quad_q   <= 1'b0;
            wide_q   <= 1'b0;
            cur_addr <= '0;
            wr_byte  <= '0;
            op_std   <= '0;
            op_quad  <= '0;
        end else begin
            if (cmd_start) begin
                busy  <= 1'b1;
                cmd_q <= reg_wdata;
            end else if (cmd_done) begin
                busy     <= 1'b0;
                cur_addr <= cur_addr + 1'b1;
                if (cmd_q != CMD_WR) rdata_q <= rx_byte;
            end
            if (host_wr) begin
                for (int i = 0; i < ADDR_BYTES; i++) begin
                    if (reg_addr == addr_ofs(i)) cur_addr[i*8 +: 8] <= reg_wdata;
                end
                case (reg_addr)
                    OFS_WDATA:   wr_byte <= reg_wdata;
                    OFS_OP_STD:  op_std  <= reg_wdata;
                    OFS_OP_QUAD: op_quad <= reg_wdata;
                    OFS_CFG:     fast_q  <= reg_wdata[0];
                    OFS_LOCK:    lock_q  <= reg_wdata;
                    OFS_MODE: begin
                        dual_q <= reg_wdata[0];
                        quad_q <= reg_wdata[2];
                        wide_q <= reg_wdata[4];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (reg_addr == addr_ofs(i)) reg_rdata = cur_addr[i*8 +: 8];
        end
        case (reg_addr)
            OFS_CMD:     reg_rdata = busy ? cmd_q : 8'h00;
            OFS_RDATA:   reg_rdata = rdata_q;
            OFS_WDATA:   reg_rdata = wr_byte;
            OFS_OP_STD:  reg_rdata = op_std;
            OFS_OP_QUAD: reg_rdata = op_quad;
            OFS_CFG:     reg_rdata = {7'b0, fast_q};
            OFS_LOCK:    reg_rdata = lock_q;
            OFS_MODE:    reg_rdata = {3'b0, wide_q, 1'b0, quad_q, 1'b0, dual_q};
            default: ;
        endcase
    end

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cur_addr)); // R10
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_done) && $past(busy) |-> cur_addr == $past(cur_addr) + 1'b1); // R9

endmodule

// File: rtl/fseq_shifter.sv
// Serial segment engine: runs one run of mode-0 clocks that either shifts
// out bits on IO0, idles (dummy), or samples 1, 2 or 4 lines. Assumes a
// new segment is requested only once the previous one has finished.
module fseq_shifter
    import fseq_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seg_start,
    input  seg_e        seg_kind,
    input  lane_e       seg_lanes,
    input  logic [5:0]  seg_clks,
    input  logic [31:0] seg_data,
    input  logic [3:0]  io_in,
    output logic        sck,
    output logic        mosi,
    output logic        mosi_oe,
    output logic [7:0]  rx_byte,
    output logic        seg_done
);

    localparam int HALF_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SCK_HALF - 1);

    logic              active;
    logic [HALF_W-1:0] half_cnt;
    logic [5:0]        clk_cnt;
    logic [5:0]        clks_q;
    logic [31:0]       tx_sh;
    seg_e              kind_q;
    lane_e             lanes_q;

    // Output decode: only transmit segments drive IO0
    always_comb begin
        mosi    = tx_sh[31];
        mosi_oe = active && (kind_q == SEG_TX);
    end

    // Clock generation, bit shifting and sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            half_cnt <= '0;
            clk_cnt  <= '0;
            clks_q   <= '0;
            tx_sh    <= '0;
            kind_q   <= SEG_DUMMY;
            lanes_q  <= LANE_1;
            sck      <= 1'b0;
            rx_byte  <= '0;
            seg_done <= 1'b0;
        end else begin
            seg_done <= 1'b0;
            if (seg_start) begin
                active   <= 1'b1;
                half_cnt <= '0;
                clk_cnt  <= '0;
                clks_q   <= seg_clks;
                tx_sh    <= seg_data;
                kind_q   <= seg_kind;
                lanes_q  <= seg_lanes;
                sck      <= 1'b0;
            end else if (active) begin
                if (half_cnt == HALF_LAST) begin
                    half_cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        if (kind_q == SEG_RX) begin
                            case (lanes_q)
                                LANE_1:  rx_byte <= {rx_byte[6:0], io_in[1]};
                                LANE_2:  rx_byte <= {rx_byte[5:0], io_in[1:0]};
                                default: rx_byte <= {rx_byte[3:0], io_in[3:0]};
                            endcase
                        end
                    end else begin
                        sck   <= 1'b0;
                        tx_sh <= {tx_sh[30:0], 1'b0};
                        if (clk_cnt == clks_q - 6'd1) begin
                            active   <= 1'b0;
                            seg_done <= 1'b1;
                        end else begin
                            clk_cnt <= clk_cnt + 6'd1;
                        end
                    end
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end
        end
    end

    AST_SEG_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start |-> !active); // R11
    AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |-> !sck && !active); // R11

endmodule

// File: rtl/fseq_ctrl.sv
// Command sequencer: turns a host read or write command into chip-select
// frames made of shifter segments, including the status poll after a
// program. Assumes configuration inputs are stable while a command runs.
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              start_is_wr,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [7:0]        wr_byte,
    input  logic [7:0]        op_std,
    input  logic [7:0]        op_quad,
    input  rd_cfg_t           rd_cfg,
    input  logic              seg_done,
    input  logic              flash_busy,
    output logic              seg_start,
    output seg_e              seg_kind,
    output lane_e             seg_lanes,
    output logic [5:0]        seg_clks,
    output logic [31:0]       seg_data,
    output logic              cs_n,
    output logic              cmd_done
);

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_OP, ST_RD_ADR, ST_RD_DMY, ST_RD_DAT,
        ST_WE_OP, ST_WE_GAP, ST_PP_OP, ST_PP_ADR, ST_PP_DAT, ST_PP_GAP,
        ST_SR_OP, ST_SR_DAT, ST_SR_GAP, ST_FIN
    } st_e;

    st_e  state, state_n;
    logic launched;
    logic in_seg;
    logic needs_dummy;
    logic [31:0] addr_field;

    // Frame decode: which states carry a segment, chip select, completion
    always_comb begin
        in_seg = !(state inside {ST_IDLE, ST_WE_GAP, ST_PP_GAP, ST_SR_GAP, ST_FIN});
        cs_n   = !in_seg;
        cmd_done    = (state == ST_FIN);
        seg_start   = in_seg && !launched;
        needs_dummy = rd_cfg.fast || rd_cfg.dual || rd_cfg.quad;
        addr_field  = rd_cfg.four_byte ? cur_addr : {cur_addr[23:0], 8'h00};
    end

    // Segment description for the current state
    always_comb begin
        seg_kind  = SEG_TX;
        seg_lanes = LANE_1;
        seg_clks  = 6'd8;
        seg_data  = '0;
        case (state)
            ST_RD_OP:  seg_data = {(rd_cfg.quad ? op_quad : op_std), 24'h0};
            ST_RD_ADR, ST_PP_ADR: begin
                seg_clks = rd_cfg.four_byte ? 6'd32 : 6'd24;
                seg_data = addr_field;
            end
            ST_RD_DMY: seg_kind = SEG_DUMMY;
            ST_RD_DAT: begin
                seg_kind = SEG_RX;
                if (rd_cfg.quad) begin
                    seg_lanes = LANE_4;
                    seg_clks  = 6'd2;
                end else if (rd_cfg.dual) begin
                    seg_lanes = LANE_2;
                    seg_clks  = 6'd4;
                end
            end
            ST_WE_OP:  seg_data = {FL_WREN, 24'h0};
            ST_PP_OP:  seg_data = {FL_PROG, 24'h0};
            ST_PP_DAT: seg_data = {wr_byte, 24'h0};
            ST_SR_OP:  seg_data = {FL_STAT, 24'h0};
            ST_SR_DAT: seg_kind = SEG_RX;
            default: ;
        endcase
    end

    // Next-state selection
    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:   if (cmd_start) state_n = start_is_wr ? ST_WE_OP : ST_RD_OP;
            ST_RD_OP:  if (seg_done) state_n = ST_RD_ADR;
            ST_RD_ADR: if (seg_done) state_n = needs_dummy ? ST_RD_DMY : ST_RD_DAT;
            ST_RD_DMY: if (seg_done) state_n = ST_RD_DAT;
            ST_RD_DAT: if (seg_done) state_n = ST_FIN;
            ST_WE_OP:  if (seg_done) state_n = ST_WE_GAP;
            ST_WE_GAP: state_n = ST_PP_OP;
            ST_PP_OP:  if (seg_done) state_n = ST_PP_ADR;
            ST_PP_ADR: if (seg_done) state_n = ST_PP_DAT;
            ST_PP_DAT: if (seg_done) state_n = ST_PP_GAP;
            ST_PP_GAP: state_n = ST_SR_OP;
            ST_SR_OP:  if (seg_done) state_n = ST_SR_DAT;
            ST_SR_DAT: if (seg_done) state_n = flash_busy ? ST_SR_GAP : ST_FIN;
            ST_SR_GAP: state_n = ST_SR_OP;
            ST_FIN:    state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // State register and one-launch-per-segment tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            launched <= 1'b0;
        end else begin
            state <= state_n;
            if (seg_start)     launched <= 1'b1;
            else if (seg_done) launched <= 1'b0;
        end
    end

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> state == ST_IDLE); // R10
    AST_FIN_AFTER_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(seg_done)); // R8

endmodule

// File: rtl/spi_byte_seq.sv
// Top of the SPI flash byte-access sequencer: register window, command
// sequencer and serial segment engine. Assumes a mode-0 flash on the IO
// lines and a host that polls the command register for completion.
module spi_byte_seq
    import fseq_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic [3:0] spi_io_out,
    output logic [3:0] spi_io_oe,
    input  logic [3:0] spi_io_in
);

    logic              busy, cmd_start, start_is_wr, unlocked, cmd_done;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        wr_byte, op_std, op_quad, rx_byte;
    rd_cfg_t           rd_cfg;
    logic              seg_start, seg_done, mosi, mosi_oe;
    seg_e              seg_kind;
    lane_e             seg_lanes;
    logic [5:0]        seg_clks;
    logic [31:0]       seg_data;

    fseq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_done(cmd_done),
        .rx_byte(rx_byte), .busy(busy), .cmd_start(cmd_start),
        .start_is_wr(start_is_wr), .unlocked(unlocked), .cur_addr(cur_addr),
        .wr_byte(wr_byte), .op_std(op_std), .op_quad(op_quad), .rd_cfg(rd_cfg)
    );

    fseq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_is_wr(start_is_wr),
        .cur_addr(cur_addr), .wr_byte(wr_byte), .op_std(op_std), .op_quad(op_quad),
        .rd_cfg(rd_cfg), .seg_done(seg_done), .flash_busy(rx_byte[0]),
        .seg_start(seg_start), .seg_kind(seg_kind), .seg_lanes(seg_lanes),
        .seg_clks(seg_clks), .seg_data(seg_data), .cs_n(spi_cs_n), .cmd_done(cmd_done)
    );

    fseq_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .seg_kind(seg_kind),
        .seg_lanes(seg_lanes), .seg_clks(seg_clks), .seg_data(seg_data),
        .io_in(spi_io_in), .sck(spi_sck), .mosi(mosi), .mosi_oe(mosi_oe),
        .rx_byte(rx_byte), .seg_done(seg_done)
    );

    // Only IO0 is ever driven by the block
    always_comb begin
        spi_io_out = {3'b000, mosi};
        spi_io_oe  = {3'b000, mosi_oe};
    end

    AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> spi_cs_n); // R1
    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> busy); // R2
    AST_CS_HIGH_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck && spi_io_oe == 4'h0); // R11

endmodule

// File: tb/spi_byte_seq_bench.sv
`timescale 1ns/1ps
module spi_byte_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_cs_n, spi_sck;
    logic [3:0] spi_io_out, spi_io_oe;
    logic [3:0] drv = 4'h0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit mon_on  = 1'b0;
    bit expect_active = 1'b0;
    bit m_addr4 = 1'b0;

    always #2 clk = ~clk;

    spi_byte_seq u_spi_byte_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
        .spi_io_in(drv)
    );

    // ---------------- behavioural flash ----------------
    logic [7:0] mem [int unsigned];
    int   f_pos;
    logic [7:0]  f_op;
    logic [31:0] f_addr;
    logic [7:0]  f_dat;
    bit   wel = 1'b0;
    int   busy_cnt = 0;
    logic [7:0]  fr_op[$];
    logic [31:0] fr_addr[$];
    logic [7:0]  fr_dat[$];
    int          fr_len[$];

    function automatic logic [7:0] mem_val(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'h5A;
    endfunction

    function automatic int op_aw(input logic [7:0] op);
        if (op inside {8'h03, 8'h0B, 8'h3B, 8'h6B, 8'h02}) return m_addr4 ? 32 : 24;
        return 0;
    endfunction

    function automatic int op_dummy(input logic [7:0] op);
        return (op inside {8'h0B, 8'h3B, 8'h6B}) ? 8 : 0;
    endfunction

    function automatic int op_lanes(input logic [7:0] op);
        if (op == 8'h3B) return 2;
        if (op == 8'h6B) return 4;
        return 1;
    endfunction

    always @(negedge spi_cs_n) begin
        f_pos = 0; f_op = '0; f_addr = '0; f_dat = '0; drv = 4'h0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (f_pos < 8) f_op = {f_op[6:0], spi_io_out[0]};
            else if (f_pos < 8 + op_aw(f_op)) f_addr = {f_addr[30:0], spi_io_out[0]};
            else if (f_op == 8'h02 && f_pos < 8 + op_aw(f_op) + 8) f_dat = {f_dat[6:0], spi_io_out[0]};
            f_pos++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && f_pos >= 8) begin
            int hdr, idx, ln;
            logic [7:0] b, sh;
            hdr = 8 + op_aw(f_op) + op_dummy(f_op);
            ln  = op_lanes(f_op);
            idx = f_pos - hdr;
            if (f_op == 8'h05) b = {7'b0, busy_cnt > 0};
            else b = mem_val(m_addr4 ? f_addr : {8'h00, f_addr[23:0]});
            if ((f_op inside {8'h03, 8'h0B, 8'h3B, 8'h6B, 8'h05}) && idx >= 0 && idx * ln < 8) begin
                sh = b << (idx * ln);
                if (ln == 1)      drv = {2'b00, sh[7], 1'b0};
                else if (ln == 2) drv = {2'b00, sh[7:6]};
                else              drv = sh[7:4];
            end else begin
                drv = 4'h0;
            end
        end
    end

    always @(posedge spi_cs_n) begin
        if (mon_on) begin
            fr_op.push_back(f_op);
            fr_addr.push_back(f_addr);
            fr_dat.push_back(f_dat);
            fr_len.push_back(f_pos);
            if (f_op == 8'h06) wel = 1'b1;
            if (f_op == 8'h02 && wel && f_pos == 8 + op_aw(8'h02) + 8) begin
                mem[m_addr4 ? f_addr : {8'h00, f_addr[23:0]}] = f_dat;
                busy_cnt = 3;
                wel = 1'b0;
            end else if (f_op == 8'h05 && busy_cnt > 0) begin
                busy_cnt--;
            end
        end
        drv = 4'h0;
    end

    // ---------------- per-cycle reference checks ----------------
    always @(negedge clk) begin
        cycles++;
        if (mon_on) begin
            if (spi_cs_n && (spi_sck || spi_io_oe != 4'h0)) begin
                n_fail++;
                $display("FAIL R11 idle lines: sck=%0b oe=%h expected 0/0", spi_sck, spi_io_oe);
            end
            if (!expect_active && !spi_cs_n) begin
                n_fail++;
                $display("FAIL R1/R10 unexpected frame: cs_n=%0b expected 1", spi_cs_n);
            end
        end
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    // ---------------- host helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_addr(input logic [31:0] a);
        wr(8'h10, a[7:0]); wr(8'h14, a[15:8]); wr(8'h18, a[23:16]); wr(8'hC8, a[31:24]);
    endtask

    task automatic get_addr(output logic [31:0] a);
        logic [7:0] v;
        rd(8'h10, v); a[7:0] = v;
        rd(8'h14, v); a[15:8] = v;
        rd(8'h18, v); a[23:16] = v;
        rd(8'hC8, v); a[31:24] = v;
    endtask

    task automatic clear_frames();
        fr_op.delete(); fr_addr.delete(); fr_dat.delete(); fr_len.delete();
    endtask

    task automatic wait_done();
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h00, v);
            if ((v & 8'h1F) == 8'h00) break;
        end
        repeat (2) @(negedge clk);
        expect_active = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] code);
        logic [7:0] v;
        clear_frames();
        expect_active = 1'b1;
        wr(8'h00, code);
        rd(8'h00, v);
        chk(v == code, "R2 busy readback", v, code);
        wait_done();
        rd(8'h00, v);
        chk(v == 8'h00, "R2 cleared readback", v, 8'h00);
    endtask

    task automatic read_check(input logic [31:0] a, input logic [7:0] op, input int len, input string tag);
        logic [7:0] v;
        logic [31:0] na;
        run_cmd(8'h81);
        rd(8'h0C, v);
        chk(v == mem_val(a), {tag, " data"}, v, mem_val(a));
        chk(fr_op.size() == 1 && fr_op[0] == op, {tag, " opcode"}, fr_op.size() ? fr_op[0] : 0, op);
        chk(fr_len.size() == 1 && fr_len[0] == len, {tag, " frame clocks"}, fr_len.size() ? fr_len[0] : 0, len);
        get_addr(na);
        chk(na == a + 1, "R9 address advance", na, a + 1);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] v;
        logic [31:0] a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_frames();
        mon_on = 1'b1;

        // R11 reset state
        rd(8'h00, v); chk(v == 0, "R11 reset cmd", v, 0);
        rd(8'h0C, v); chk(v == 0, "R11 reset rdata", v, 0);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11 reset pins", {spi_cs_n, spi_sck}, 2'b10);

        // R1 locked: command ignored
        set_addr(32'h0000_0123);
        wr(8'h2C, 8'h03);
        wr(8'h00, 8'h81);
        rd(8'h00, v); chk(v == 0, "R1 locked cmd readback", v, 0);
        repeat (40) @(negedge clk);
        chk(fr_op.size() == 0, "R1 locked no frame", fr_op.size(), 0);
        get_addr(a); chk(a == 32'h123, "R1 locked address kept", a, 32'h123);

        wr(8'hC4, 8'h30);

        // R3 plain single read, no dummy
        read_check(32'h123, 8'h03, 40, "R3 plain read");
        chk(fr_addr[0] == 32'h124 - 1, "R3 address sent", fr_addr[0], 32'h123);

        // R4 fast read, two streamed bytes
        wr(8'h60, 8'h01); wr(8'h2C, 8'h0B);
        read_check(32'h124, 8'h0B, 48, "R4 fast read");
        read_check(32'h125, 8'h0B, 48, "R4 fast read stream");

        // R5 dual read
        wr(8'h60, 8'h00); wr(8'hCC, 8'h01); wr(8'h2C, 8'h3B);
        read_check(32'h126, 8'h3B, 44, "R5 dual read");

        // R6 quad read, quad wins over dual
        wr(8'hCC, 8'h05); wr(8'h30, 8'h6B);
        read_check(32'h127, 8'h6B, 42, "R6 quad read");

        // R7 four-byte addressing with carry (R9)
        wr(8'hCC, 8'h10); wr(8'h60, 8'h01); wr(8'h2C, 8'h0B);
        m_addr4 = 1'b1;
        set_addr(32'h9A34_56FF);
        read_check(32'h9A34_56FF, 8'h0B, 56, "R7 wide read");
        chk(fr_addr[0] == 32'h9A34_56FF, "R7 32-bit address sent", fr_addr[0], 32'h9A34_56FF);

        // R8 single-byte write with status polling
        wr(8'hCC, 8'h00); wr(8'h60, 8'h00); wr(8'h2C, 8'h03);
        m_addr4 = 1'b0;
        set_addr(32'h0000_0200);
        wr(8'h1C, 8'hC3);
        run_cmd(8'h90);
        chk(fr_op.size() == 6, "R8 frame count", fr_op.size(), 6);
        if (fr_op.size() == 6) begin
            chk(fr_op[0] == 8'h06 && fr_len[0] == 8, "R8 write-enable frame", {fr_op[0], fr_len[0][7:0]}, 16'h0608);
            chk(fr_op[1] == 8'h02 && fr_addr[1] == 32'h200 && fr_dat[1] == 8'hC3, "R8 program frame",
                {fr_op[1], fr_dat[1]}, 16'h02C3);
            chk(fr_op[2] == 8'h05 && fr_op[5] == 8'h05, "R8 status polls", {fr_op[2], fr_op[5]}, 16'h0505);
        end
        get_addr(a); chk(a == 32'h201, "R9 advance after write", a, 32'h201);
        set_addr(32'h0000_0200);
        run_cmd(8'h81);
        rd(8'h0C, v); chk(v == 8'hC3, "R8 programmed byte read back", v, 8'hC3);

        // R10 writes during a command are dropped
        clear_frames();
        expect_active = 1'b1;
        wr(8'h00, 8'h81);
        wr(8'h10, 8'hEE);
        wr(8'h00, 8'h90);
        wait_done();
        chk(fr_op.size() == 1 && fr_op[0] == 8'h03, "R10 second command dropped", fr_op.size(), 1);
        get_addr(a); chk(a == 32'h202, "R10 address write dropped", a, 32'h202);

        // R10 unknown command code ignored
        clear_frames();
        wr(8'h00, 8'h55);
        rd(8'h00, v); chk(v == 0, "R10 unknown code readback", v, 0);
        repeat (40) @(negedge clk);
        chk(fr_op.size() == 0, "R10 unknown code no frame", fr_op.size(), 0);

        n_tests++; // per-cycle monitor (R1, R10, R11)
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule